// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the control front end of a flow-through synchronous SRAM. Each word is built from four lanes, and each lane is eight data bits plus one parity bit. On every rising clock edge the block samples three chip enables and two start strobes. The first strobe is the processor strobe. The second is the cache-controller strobe. It also samples an advance input, a global write, a byte-write enable and four lane selects. From these it classifies the cycle as one of five kinds: burst start, burst continue, burst hold, write or deselect.

It generates the per-lane write strobes into a behavioural array and keeps track of the burst address. It also decides when read data may be driven. There is no output register, so read data comes straight from the array at the address registered on the last edge.

A burst begins at an external address. After that, the two low address bits step through four positions in one of two orders. In linear order they count upward and wrap. In interleaved order they are the start bits XORed with a count. The order is latched when the burst starts.

Top module: `sbc_ctrl`

## Requirements
- R1: After synchronous reset, `dout_en` is low, `dout` is zero and the device is deselected. Continue or hold cycles issued before the first start strobe write nothing.
- R2: Lane n is bits [9n+8:9n] of `din`/`dout` (data plus parity). With `gw_n` high and `bwe_n` low, a low `bw_n[n]` writes lane n. Lanes whose select is high keep their contents.
- R3: A low `gw_n` writes all four lanes, whatever the values of `bwe_n` and `bw_n`.
- R4: A cycle is a read when `gw_n` and `bwe_n` are both high. It is also a read when `bwe_n` is low but all four `bw_n` bits are high.
- R5: While `ce_n` is high, a low `adsp_n` is ignored. If `adsc_n` is also high, the cycle acts as a continue or hold cycle.
- R6: A low `adsc_n` while `ce_n` is high deselects the device.
- R7: A start strobe selects the device only when `ce_n`=0, `ce2`=1 and `ce2_n`=0. Any other combination seen with a start strobe deselects the device, and `dout_en` is low afterwards.
- R8: When no start strobe is active, `ce2` and `ce2_n` have no effect.
- R9: An accepted processor strobe always starts a read at the external address, even if the write inputs are active. A following cycle with no strobe, `adv_n` high and active write inputs writes that same address.
- R10: A cache-controller strobe that the processor strobe does not override starts a read or a write at the external address. The write inputs in that same cycle decide which.
- R11: With no start strobe, a low `adv_n` moves to the next burst address. In linear mode (`lin_burst`=1 at start) the low two bits are (start+k) mod 4. In interleaved mode they are start XOR k. The upper bits never change within a burst.
- R12: With no start strobe and `adv_n` high, the cycle reuses the current address. It may be a read or a write.
- R13: After each edge, `dout_en` = not `oe_n` AND selected AND last cycle was a read. `dout` then shows the word at that cycle's address, and zero when `dout_en` is low.
- R14: After a deselect, continue and hold cycles neither write nor enable the output until a new accepted start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | External burst start address |
| adsp_n | input | 1 | Processor start strobe, active low |
| adsc_n | input | 1 | Cache-controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce2_n | input | 1 | Secondary chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low |
| lin_burst | input | 1 | 1 = linear order, 0 = interleaved (latched at start) |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | Read data is being driven |

## Verification
The hardest case to reach is the two-cycle processor-strobe write. The strobe must be accepted with the write inputs already active, and the data must still land only on the following edge at the unchanged address. The bench reaches this with directed sequences, and the random mix also produces it often because the strobes are biased towards short bursts.

A second hard case is a deselect that arrives in the middle of a burst through a bad secondary enable, followed by continue writes. Those writes must leave no trace. This is shown by restarting a read at the affected addresses.

// File: rtl/sbc_pkg.sv
// Shared constants and the burst-order helper for the burst SRAM controller.
// Assumes a burst of four beats (two low address bits).
package sbc_pkg;
    localparam int LANES_DEF  = 4;
    localparam int LANE_W_DEF = 9;
    localparam int BEAT_W     = 2;

    // Low address bits for beat k of a burst starting at st.
    function automatic logic [BEAT_W-1:0] beat_lo(input logic [BEAT_W-1:0] st,
                                                 input logic [BEAT_W-1:0] k,
                                                 input logic lin);
        return lin ? (st + k) : (st ^ k);
    endfunction
endpackage

// File: rtl/sbc_decode.sv
// Cycle decoder: turns strobes, enables and write inputs into load / deselect /
// step / live indications and per-lane write strobes.
// Assumes sel_q is the registered "device selected" state of the controller.
module sbc_decode #(
    parameter int LANES = 4
) (
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             ce_n,
    input  logic             ce2,
    input  logic             ce2_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             sel_q,
    output logic             load,
    output logic             desel,
    output logic             step,
    output logic             live,
    output logic [LANES-1:0] we
);
    logic             p_act;
    logic             strt;
    logic             en_ok;
    logic [LANES-1:0] req;

    // Strobe qualification and chip-enable check.
    always_comb begin
        p_act = !adsp_n && !ce_n;
        strt  = p_act || !adsc_n;
        en_ok = !ce_n && ce2 && !ce2_n;
        load  = strt && en_ok;
        desel = strt && !en_ok;
        live  = load || (!strt && sel_q);
        step  = !strt && sel_q && !adv_n;
    end

    // Write-type selection: global override, else gated lane selects.
    always_comb begin
        if (!gw_n)       req = '1;
        else if (!bwe_n) req = ~bw_n;
        else             req = '0;
        we = ((load && !p_act) || (!strt && sel_q)) ? req : '0;
    end
endmodule

// File: rtl/sbc_burst.sv
// Burst address unit: latches the start address and order, advances a
// two-bit beat count, and presents this cycle's address and the registered
// read address. Assumes AW >= 3.
module sbc_burst #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          lin,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] cyc_addr,
    output logic [AW-1:0] rd_addr_q
);
    import sbc_pkg::*;
    localparam int HI_W = AW - BEAT_W;

    logic [HI_W-1:0]   hi_q, hi_d;
    logic [BEAT_W-1:0] st_q, st_d, cnt_q, cnt_d;
    logic              lin_q, lin_d;

    // Next burst state and the address used by this cycle.
    always_comb begin
        hi_d  = load ? ext_addr[AW-1:BEAT_W] : hi_q;
        st_d  = load ? ext_addr[BEAT_W-1:0]  : st_q;
        lin_d = load ? lin : lin_q;
        cnt_d = load ? '0 : (step ? cnt_q + 1'b1 : cnt_q);
        cyc_addr = {hi_d, beat_lo(st_d, cnt_d, lin_d)};
    end

    // Burst state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0; st_q <= '0; cnt_q <= '0; lin_q <= 1'b0; rd_addr_q <= '0;
        end else begin
            hi_q <= hi_d; st_q <= st_d; cnt_q <= cnt_d; lin_q <= lin_d;
            rd_addr_q <= cyc_addr;
        end
    end

    a_r12_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(rd_addr_q));
    a_r11_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step) |=> (rd_addr_q[AW-1:BEAT_W] == $past(rd_addr_q[AW-1:BEAT_W])));
endmodule

// File: rtl/sbc_array.sv
// Behavioural array: one storage column per lane, synchronous per-lane write,
// combinational read of a registered address. Contents are not reset.
module sbc_array #(
    parameter int AW     = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] col [DEPTH];
        // Lane write on the clock edge.
        always_ff @(posedge clk) begin
            if (we[g]) col[waddr] <= wdata[g*LANE_W +: LANE_W];
        end
        // Flow-through lane read.
        assign rdata[g*LANE_W +: LANE_W] = col[raddr];
    end
endmodule

// File: rtl/sbc_ctrl.sv
// Top of the burst SRAM cycle controller: decoder, burst address unit,
// array, and the select/read-state registers that gate the flow-through output.
// Assumes all inputs are synchronous to clk except oe_n, which gates combinationally.
module sbc_ctrl #(
    parameter int AW     = 8,
    parameter int LANES  = sbc_pkg::LANES_DEF,
    parameter int LANE_W = sbc_pkg::LANE_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    ce_n,
    input  logic                    ce2,
    input  logic                    ce2_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic                    lin_burst,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    localparam int WORD_W = LANES * LANE_W;

    logic              load, desel, step, live;
    logic [LANES-1:0]  we;
    logic              sel_q, rd_q;
    logic [AW-1:0]     cyc_addr, rd_addr_q;
    logic [WORD_W-1:0] rdata;

    sbc_decode #(.LANES(LANES)) u_dec (
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .ce_n(ce_n),
        .ce2(ce2), .ce2_n(ce2_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .sel_q(sel_q), .load(load), .desel(desel), .step(step), .live(live), .we(we)
    );

    sbc_burst #(.AW(AW)) u_burst (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .lin(lin_burst),
        .ext_addr(addr), .cyc_addr(cyc_addr), .rd_addr_q(rd_addr_q)
    );

    sbc_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .we(we), .waddr(cyc_addr), .wdata(din),
        .raddr(rd_addr_q), .rdata(rdata)
    );

    // Selected / last-cycle-was-read state.
    always_ff @(posedge clk) begin
        if (!rst_n || desel) begin
            sel_q <= 1'b0;
            rd_q  <= 1'b0;
        end else if (live) begin
            sel_q <= 1'b1;
            rd_q  <= (we == '0);
        end
    end

    // Output gating of the flow-through read data.
    always_comb begin
        dout_en = !oe_n && sel_q && rd_q;
        dout    = dout_en ? rdata : '0;
    end

    a_r7_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> !dout_en);
    a_r9_adsp_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce_n) |-> (we == '0));
    a_r14_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_q && adsc_n && (adsp_n || ce_n)) |-> (we == '0));
    a_r3_global_all: assert property (@(posedge clk) disable iff (!rst_n)
        (!gw_n && (we != '0)) |-> (we == '1));
    a_r13_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (we != '0) |=> !dout_en);
endmodule

// File: tb/sbc_ctrl_test.sv
`timescale 1ns/1ps
module sbc_ctrl_test;
    localparam int AW = 8;
    localparam int WW = 36;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          adsp_n, adsc_n, adv_n, ce_n, ce2, ce2_n, gw_n, bwe_n, oe_n, lin_burst;
    logic [3:0]    bw_n;
    logic [WW-1:0] din;
    logic [WW-1:0] dout;
    logic          dout_en;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sbc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .lin_burst(lin_burst),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    // Reference model state
    logic [WW-1:0] m_mem [256];
    logic [3:0]    m_kn  [256];
    bit m_sel, m_rd, m_lin;
    int m_hi, m_st, m_cnt, m_cur;

    function automatic logic [3:0] req_mask();
        if (!gw_n) return 4'hf;
        if (!bwe_n) return ~bw_n;
        return 4'h0;
    endfunction

    function automatic int beat_addr();
        int lo;
        lo = m_lin ? ((m_st + m_cnt) & 3) : (m_st ^ m_cnt);
        return m_hi * 4 + lo;
    endfunction

    task automatic idle();
        adsp_n = 1; adsc_n = 1; adv_n = 1; ce_n = 0; ce2 = 1; ce2_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = 4'hf; oe_n = 0;
    endtask

    task automatic chk(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock cycle: predict, clock, check.
    task automatic tick(string tag);
        bit p_act, strt, en;
        logic [3:0] wm;
        bit exp_en;
        logic [WW-1:0] exp_d;
        p_act = !adsp_n && !ce_n;
        strt  = p_act || !adsc_n;
        en    = !ce_n && ce2 && !ce2_n;
        wm    = 4'h0;
        if (strt && !en) begin
            m_sel = 0; m_rd = 0;
        end else if (strt) begin
            m_hi = int'(addr) / 4; m_st = int'(addr) % 4; m_cnt = 0; m_lin = lin_burst;
            m_sel = 1; wm = p_act ? 4'h0 : req_mask();
        end else if (m_sel) begin
            if (!adv_n) m_cnt = (m_cnt + 1) & 3;
            wm = req_mask();
        end
        if (m_sel) begin
            m_cur = beat_addr();
            m_rd  = (wm == 4'h0);
            for (int n = 0; n < 4; n++)
                if (wm[n]) begin
                    m_mem[m_cur][n*9 +: 9] = din[n*9 +: 9];
                    m_kn[m_cur][n] = 1'b1;
                end
        end
        @(posedge clk);
        #1;
        exp_en = !oe_n && m_sel && m_rd;
        chk({tag, " dout_en"}, {35'd0, dout_en}, {35'd0, exp_en});
        if (!exp_en) chk({tag, " dout idle"}, dout, '0);
        else if (m_kn[m_cur] == 4'hf) begin
            exp_d = m_mem[m_cur];
            chk({tag, " dout"}, dout, exp_d);
        end
    endtask

    task automatic start_c(logic [AW-1:0] a, bit lin);
        idle(); adsc_n = 0; addr = a; lin_burst = lin;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 256; i++) begin m_kn[i] = 4'h0; m_mem[i] = '0; end
        m_sel = 0; m_rd = 0; m_lin = 0; m_hi = 0; m_st = 0; m_cnt = 0; m_cur = 0;
        idle(); addr = '0; lin_burst = 1; din = '0; rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset dout_en", {35'd0, dout_en}, 36'd0);
        chk("R1 reset dout", dout, '0);
        rst_n = 1;
        // R1/R14: continue write before any start must not store
        idle(); adv_n = 0; gw_n = 0; din = 36'hbad_bad_bad; tick("R14 pre-start write");
        start_c(8'd0, 1); tick("R1 read after reset");
        // R3 preload words 0..15 with global write (bwe_n/bw_n ignored)
        for (int i = 0; i < 16; i++) begin
            start_c(i[AW-1:0], 1); gw_n = 0; bwe_n = 1; bw_n = 4'h0;
            din = {4'h1, i[7:0], 24'h000000} ^ 36'(i * 32'h01010101);
            tick("R3 global write");
        end
        start_c(8'd4, 1); tick("R3 readback");
        // R2 lane 1 only
        start_c(8'd4, 1); bwe_n = 0; bw_n = 4'b1101; din = 36'hf_ffff_ffff; tick("R2 lane write");
        start_c(8'd4, 1); tick("R2 readback");
        // R4 bwe low with all selects high is a read
        start_c(8'd4, 1); bwe_n = 0; bw_n = 4'hf; din = 36'h0; tick("R4 read form");
        start_c(8'd4, 1); tick("R4 readback");
        // R11 linear burst from 5, then interleaved from 5
        start_c(8'd5, 1); tick("R11 lin start");
        for (int k = 0; k < 4; k++) begin idle(); adv_n = 0; tick("R11 lin step"); end
        start_c(8'd5, 0); tick("R11 il start");
        for (int k = 0; k < 4; k++) begin idle(); adv_n = 0; tick("R11 il step"); end
        // R12 hold, then R13 oe gating
        idle(); tick("R12 hold");
        idle(); oe_n = 1; tick("R13 oe high");
        idle(); tick("R13 oe low");
        // R9 processor strobe with write inputs, then write next edge
        idle(); adsp_n = 0; addr = 8'd8; gw_n = 0; din = 36'h9_1234_5678; tick("R9 adsp read");
        idle(); gw_n = 0; din = 36'h9_8765_4321; tick("R9 follow write");
        idle(); adsp_n = 0; addr = 8'd8; tick("R9 readback");
        // R5 blocked processor strobe acts as hold
        idle(); ce_n = 1; adsp_n = 0; addr = 8'd2; tick("R5 blocked adsp");
        // R8 secondary enables ignored without start
        idle(); ce2 = 0; ce2_n = 1; adv_n = 0; tick("R8 no start");
        // R6 adsc with ce_n high deselects, R14 writes then ignored
        idle(); ce_n = 1; adsc_n = 0; addr = 8'd3; tick("R6 deselect");
        idle(); adv_n = 0; gw_n = 0; din = '0; tick("R14 ignored write");
        idle(); gw_n = 0; din = '0; tick("R14 ignored hold write");
        // R7 secondary enable wrong with start
        start_c(8'd10, 1); tick("R7 select");
        start_c(8'd10, 1); ce2 = 0; tick("R7 ce2 low");
        start_c(8'd10, 1); ce2_n = 1; tick("R7 ce2_n high");
        idle(); adv_n = 0; gw_n = 0; din = '0; tick("R14 after R7");
        for (int i = 8; i < 12; i++) begin start_c(i[AW-1:0], 1); tick("R14 readback"); end
        // R10 adsc write then read
        start_c(8'd12, 1); gw_n = 0; din = 36'ha_5a5a_5a5a; tick("R10 adsc write");
        start_c(8'd12, 1); tick("R10 readback");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            idle();
            adsp_n = ($urandom % 4) != 0;
            adsc_n = ($urandom % 4) != 0;
            adv_n  = $urandom % 2;
            ce_n   = ($urandom % 8) == 0;
            ce2    = ($urandom % 8) != 0;
            ce2_n  = ($urandom % 8) == 0;
            gw_n   = ($urandom % 8) != 0;
            bwe_n  = $urandom % 2;
            bw_n   = 4'($urandom);
            oe_n   = ($urandom % 4) == 0;
            lin_burst = $urandom % 2;
            addr   = AW'($urandom % 32);
            din    = {4'($urandom), 32'($urandom)};
            tick("RND");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule